// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them, and presents one interrupt at a time to a CPU together with an 8-bit vector. Software configures it through a byte-wide register port with a single address bit. A short setup sequence of words must be written before any request is accepted. After that, software writes commands to set the mask, to end interrupts with or without rotating the priority order, to move the lowest-priority slot, and to choose what a read of address 0 returns.

Priority is tracked by a 3-bit lowest-priority pointer. The level one step above the pointer, counting upward modulo 8, has the highest priority. After setup the pointer is 7, so input 0 ranks highest. Request inputs are asynchronous. They pass through a synchronizer, and a rising edge on an unmasked input sets the matching pending bit. The interrupt output is a valid/ready pair. While `int_valid` is high, `int_vector` names the winning pending level. A cycle with both `int_valid` and `int_ready` high is the acknowledge: the level leaves the pending set and enters the in-service set. The CPU may hold `int_ready` low for as long as it likes, and nothing is lost while it does. While it waits, a newer request of higher rank can take over `int_vector`, so the CPU must use the vector of the cycle in which it accepts.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write to address 0 with bit 4 set is the first setup word. In that word, bit 1 set means single (non-cascaded) operation and bit 0 set means a mode word will follow. The write restarts setup, selects the pending register for address-0 reads, disarms poll mode, and sets the lowest-priority pointer to 7.
- R2: After the first setup word, the next write to address 1 stores the vector base (bits 7..3). The block then waits for the mode word if bit 0 of the first word was set, and otherwise becomes ready. A mode word with bits 1, 3 and 4 clear makes the block ready.
- R3: If bit 1 of the first setup word was clear (cascade), the vector-base write returns the block to the unconfigured state and sets `cmd_err`. In the unconfigured state, writes to address 1 are ignored.
- R4: A mode word with bit 1 (automatic end of interrupt), bit 3 (buffered) or bit 4 (special nesting) set sets `cmd_err`, and the block keeps waiting for a mode word.
- R5: When the block is ready, a write to address 1 loads the 8-bit mask. A read of address 1 returns the mask at any time.
- R6: A rising edge on `irq_req[n]`, after a two-flop synchronizer, sets pending bit n only if the block is ready and mask bit n is clear. Edges that arrive before ready or on a masked input are dropped.
- R7: `int_valid` is high when the highest-ranked unmasked pending level ranks strictly above every in-service level. `int_vector` is the vector base followed by that 3-bit level. On acknowledge, that level's pending bit is cleared and its in-service bit is set.
- R8: Command byte 0x20 on address 0 clears the highest-ranked in-service bit. Command 0xA0 does the same and also moves the pointer to the cleared level. Neither command changes anything when nothing is in service.
- R9: Commands 0x60|n and 0xE0|n clear in-service bit n, and 0xE0|n also sets the pointer to n. Command 0xC0|n sets the pointer to n and clears nothing. Command 0x40 changes nothing.
- R10: A write to address 0 with bit 4 clear and bit 3 set is a read-control word. If its bit 1 is set, bit 0 chooses what address 0 returns: 1 selects the in-service register, 0 selects the pending register.
- R11: A read-control word with bit 2 set arms poll mode. The next read of address 0 returns 0x80 ORed with the highest-ranked in-service level, or 0x00 if nothing is in service, and then disarms poll mode.
- R12: Command codes 0x00 and 0x80, and a read-control word with bit 6 set, set `cmd_err` and leave every register unchanged. `cmd_err` stays set until reset.
- R13: A synchronous active-high reset leaves the block unconfigured with mask, pending and in-service registers at zero and with `int_valid` and `cmd_err` low.
- R14: When an acknowledge and an end-of-interrupt command fall in the same cycle, the command acts on the in-service register as it stood before the cycle, and the acknowledged bit is then set. A rising edge captured in the same cycle as an acknowledge of the same level keeps that pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register port address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe. A poll read takes effect on it |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address (combinational) |
| irq_req | input | 8 | Asynchronous request lines, rising-edge sensitive |
| int_valid | output | 1 | Interrupt offered to the CPU |
| int_ready | input | 1 | CPU accepts the offered interrupt |
| int_vector | output | 8 | Vector base and winning level |
| cmd_err | output | 1 | Sticky error flag for unsupported setup or commands |

## Verification
The CPU acknowledge and an end-of-interrupt write can land in the same clock. Both update the in-service register, and a rotating end-of-interrupt command also moves the pointer that decides which level the acknowledge picks. The bench drives `int_ready` and a specific end-of-interrupt write for the level being acknowledged in one cycle. It also mixes acknowledges, writes and reads at random. After each step it reads the in-service register back through the port and compares it with a model that applies the command to the state before the cycle and the acknowledge after it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned N_LEVELS = 8;
  localparam int unsigned LVL_W    = $clog2(N_LEVELS);
  localparam int unsigned BASE_W   = 8 - LVL_W;

  // bit positions in address-0 writes
  localparam int unsigned B_SETUP   = 4;
  localparam int unsigned B_RDCTL   = 3;
  localparam int unsigned B_SINGLE  = 1;
  localparam int unsigned B_NEEDMD  = 0;
  localparam int unsigned B_SMASK   = 6;
  localparam int unsigned B_POLL    = 2;
  localparam int unsigned B_RSEL_EN = 1;
  localparam int unsigned B_RSEL    = 0;

  // bit positions in the mode word that request unsupported modes
  localparam int unsigned B_M_AUTO  = 1;
  localparam int unsigned B_M_BUF   = 3;
  localparam int unsigned B_M_NEST  = 4;

  typedef enum logic [1:0] {
    ST_UNCONF   = 2'd0,
    ST_WAIT_VEC = 2'd1,
    ST_WAIT_MD  = 2'd2,
    ST_READY    = 2'd3
  } setup_state_e;

  typedef enum logic [2:0] {
    OP_AUTO_CLR = 3'b000,
    OP_NS_EOI   = 3'b001,
    OP_NOP      = 3'b010,
    OP_SP_EOI   = 3'b011,
    OP_AUTO_SET = 3'b100,
    OP_NS_ROT   = 3'b101,
    OP_SET_LOW  = 3'b110,
    OP_SP_ROT   = 3'b111
  } cmd_op_e;

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], async_in[g]};
        prev <= sh[STAGES-1];
      end
    end

    assign rise[g] = sh[STAGES-1] & ~prev;

    // R6: one edge yields one capture pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> !rise[g]);
  end

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter  int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] low_ptr,
  output logic         found,
  output logic [W-1:0] level,
  output logic [W-1:0] rank
);

  // rank 0 is the level just above the pointer; scan from the weakest
  // so that the strongest set level is written last
  always_comb begin : p_scan
    logic [W-1:0] idx;
    found = 1'b0;
    level = '0;
    rank  = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = low_ptr + W'(1) + W'(i);
      if (req[idx]) begin
        found = 1'b1;
        level = idx;
        rank  = W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
  import irq_prio_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_wdata,
  input  logic                svc_found,
  input  logic [LVL_W-1:0]    svc_level,
  output logic                ready,
  output logic [N_LEVELS-1:0] mask,
  output logic [LVL_W-1:0]    low_ptr,
  output logic                rsel_isr,
  output logic                poll,
  output logic [BASE_W-1:0]   vec_base,
  output logic [N_LEVELS-1:0] isr_clr,
  output logic                err
);

  setup_state_e state;
  logic         single_q;
  logic         need_md_q;
  cmd_op_e      op;
  logic         wr_cmd0;
  logic         wr_op;
  logic         bad_mode;
  logic [LVL_W-1:0] arg_lvl;

  assign op       = cmd_op_e'(reg_wdata[7:5]);
  assign arg_lvl  = reg_wdata[LVL_W-1:0];
  assign wr_cmd0  = reg_wr && !reg_addr;
  assign wr_op    = wr_cmd0 && !reg_wdata[B_SETUP] && !reg_wdata[B_RDCTL];
  assign bad_mode = reg_wdata[B_M_AUTO] | reg_wdata[B_M_BUF] | reg_wdata[B_M_NEST];
  assign ready    = (state == ST_READY);

  // in-service clear vector for the end-of-interrupt commands
  always_comb begin
    isr_clr = '0;
    if (wr_op) begin
      unique case (op)
        OP_NS_EOI, OP_NS_ROT: if (svc_found) isr_clr[svc_level] = 1'b1;
        OP_SP_EOI, OP_SP_ROT: isr_clr[arg_lvl] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_UNCONF;
      single_q  <= 1'b0;
      need_md_q <= 1'b0;
      mask      <= '0;
      low_ptr   <= '1;
      rsel_isr  <= 1'b0;
      poll      <= 1'b0;
      vec_base  <= '0;
      err       <= 1'b0;
    end else begin
      if (reg_rd && !reg_addr && poll) poll <= 1'b0;
      if (wr_cmd0) begin
        if (reg_wdata[B_SETUP]) begin
          state     <= ST_WAIT_VEC;
          single_q  <= reg_wdata[B_SINGLE];
          need_md_q <= reg_wdata[B_NEEDMD];
          rsel_isr  <= 1'b0;
          poll      <= 1'b0;
          low_ptr   <= '1;
        end else if (reg_wdata[B_RDCTL]) begin
          if (reg_wdata[B_SMASK])       err      <= 1'b1;
          else if (reg_wdata[B_POLL])   poll     <= 1'b1;
          else if (reg_wdata[B_RSEL_EN]) rsel_isr <= reg_wdata[B_RSEL];
        end else begin
          unique case (op)
            OP_AUTO_CLR, OP_AUTO_SET: err <= 1'b1;
            OP_NS_ROT:  if (svc_found) low_ptr <= svc_level;
            OP_SP_ROT, OP_SET_LOW: low_ptr <= arg_lvl;
            default: ;
          endcase
        end
      end else if (reg_wr) begin
        unique case (state)
          ST_WAIT_VEC: begin
            vec_base <= reg_wdata[7:LVL_W];
            if (!single_q) begin
              state <= ST_UNCONF;
              err   <= 1'b1;
            end else begin
              state <= need_md_q ? ST_WAIT_MD : ST_READY;
            end
          end
          ST_WAIT_MD: begin
            if (bad_mode) err   <= 1'b1;
            else          state <= ST_READY;
          end
          ST_READY: mask <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  a_r1_setup_restart: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr && reg_wdata[B_SETUP]) |=>
      (state == ST_WAIT_VEC) && (low_ptr == '1) && !poll && !rsel_isr);

  a_r3_cascade_reject: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr && state == ST_WAIT_VEC && !single_q) |=>
      (state == ST_UNCONF) && err);

  a_r4_mode_stays: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr && state == ST_WAIT_MD && bad_mode) |=>
      (state == ST_WAIT_MD) && err);

  a_r11_poll_once: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_addr && poll && !reg_wr) |=> !poll);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r12_bad_op_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (wr_op && (op == OP_AUTO_CLR || op == OP_AUTO_SET)) |=> $stable(low_ptr));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] irq_req,
  output logic       int_valid,
  input  logic       int_ready,
  output logic [7:0] int_vector,
  output logic       cmd_err
);

  logic [N_LEVELS-1:0] irr, isr, mask, rise, cap, isr_clr, ack_vec, pend;
  logic [LVL_W-1:0]    low_ptr, pend_level, pend_rank, svc_level, svc_rank;
  logic [BASE_W-1:0]   vec_base;
  logic                ready, rsel_isr, poll, pend_found, svc_found, accept;

  irq_edge_capture #(.N(N_LEVELS), .STAGES(SYNC_STAGES)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .async_in (irq_req),
    .rise     (rise)
  );

  irq_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .svc_found (svc_found),
    .svc_level (svc_level),
    .ready     (ready),
    .mask      (mask),
    .low_ptr   (low_ptr),
    .rsel_isr  (rsel_isr),
    .poll      (poll),
    .vec_base  (vec_base),
    .isr_clr   (isr_clr),
    .err       (cmd_err)
  );

  assign pend = irr & ~mask;

  irq_prio_resolve #(.N(N_LEVELS)) u_pend_pick (
    .req     (pend),
    .low_ptr (low_ptr),
    .found   (pend_found),
    .level   (pend_level),
    .rank    (pend_rank)
  );

  irq_prio_resolve #(.N(N_LEVELS)) u_svc_pick (
    .req     (isr),
    .low_ptr (low_ptr),
    .found   (svc_found),
    .level   (svc_level),
    .rank    (svc_rank)
  );

  assign int_valid  = pend_found && (!svc_found || pend_rank < svc_rank);
  assign int_vector = {vec_base, pend_level};
  assign accept     = int_valid && int_ready;
  assign ack_vec    = accept ? (N_LEVELS'(1) << pend_level) : '0;
  assign cap        = rise & ~mask & {N_LEVELS{ready}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= (irr & ~ack_vec) | cap;
      isr <= (isr & ~isr_clr) | ack_vec;
    end
  end

  always_comb begin
    if (reg_addr)      reg_rdata = mask;
    else if (poll)     reg_rdata = svc_found ? {1'b1, {(BASE_W-1){1'b0}}, svc_level} : 8'h00;
    else if (rsel_isr) reg_rdata = isr;
    else               reg_rdata = irr;
  end

  a_r7_vector_pending: assert property (@(posedge clk) disable iff (rst)
    int_valid |-> irr[int_vector[LVL_W-1:0]] && !mask[int_vector[LVL_W-1:0]]);

  a_r7_ack_in_service: assert property (@(posedge clk) disable iff (rst)
    (int_valid && int_ready) |=> isr[$past(int_vector[LVL_W-1:0])]);

  a_r6_no_capture_unready: assert property (@(posedge clk) disable iff (rst)
    (!ready && irr == '0) |=> irr == '0);

  a_r11_poll_flag: assert property (@(posedge clk) disable iff (rst)
    (!reg_addr && poll) |-> (reg_rdata[7] == svc_found));

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, int_ready = 1'b0;
  logic [7:0] reg_wdata = 8'h00, irq_req = 8'h00;
  logic [7:0] reg_rdata, int_vector;
  logic       int_valid, cmd_err;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .int_valid(int_valid), .int_ready(int_ready), .int_vector(int_vector),
    .cmd_err(cmd_err)
  );

  int n_checks = 0, n_errs = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0] m_irr, m_isr, m_imr;
  logic [2:0] m_lp;
  logic [4:0] m_base;
  bit m_rsel, m_poll, m_err, m_sngl, m_md;
  int m_st;

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_imr = 0; m_lp = 3'd7; m_base = 0;
    m_rsel = 0; m_poll = 0; m_err = 0; m_sngl = 0; m_md = 0; m_st = 0;
  endtask

  function automatic int top_of(logic [7:0] v, logic [2:0] lp);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] l;
      l = lp + 3'd1 + 3'(i);
      if (v[l]) return int'(l);
    end
    return -1;
  endfunction

  function automatic int rank_of(int l, logic [2:0] lp);
    return (l - int'(lp) - 1) & 7;
  endfunction

  function automatic bit exp_valid();
    int p, s;
    p = top_of(m_irr & ~m_imr, m_lp);
    s = top_of(m_isr, m_lp);
    return (p >= 0) && (s < 0 || rank_of(p, m_lp) < rank_of(s, m_lp));
  endfunction

  function automatic logic [7:0] exp_read(bit a);
    int s;
    s = top_of(m_isr, m_lp);
    if (a) return m_imr;
    if (m_poll) return (s >= 0) ? (8'h80 | 8'(s)) : 8'h00;
    return m_rsel ? m_isr : m_irr;
  endfunction

  task automatic model_write(bit a, logic [7:0] d);
    int s;
    if (!a) begin
      if (d[4]) begin
        m_st = 1; m_sngl = d[1]; m_md = d[0]; m_rsel = 0; m_poll = 0; m_lp = 3'd7;
      end else if (d[3]) begin
        if (d[6]) m_err = 1;
        else if (d[2]) m_poll = 1;
        else if (d[1]) m_rsel = d[0];
      end else begin
        s = top_of(m_isr, m_lp);
        case (d[7:5])
          3'b000, 3'b100: m_err = 1;
          3'b001: if (s >= 0) m_isr[s] = 1'b0;
          3'b101: if (s >= 0) begin m_isr[s] = 1'b0; m_lp = 3'(s); end
          3'b011: m_isr[d[2:0]] = 1'b0;
          3'b111: begin m_isr[d[2:0]] = 1'b0; m_lp = d[2:0]; end
          3'b110: m_lp = d[2:0];
          default: ;
        endcase
      end
    end else begin
      case (m_st)
        1: begin
          m_base = d[7:3];
          if (!m_sngl) begin m_st = 0; m_err = 1; end
          else m_st = m_md ? 2 : 3;
        end
        2: if (d[1] | d[3] | d[4]) m_err = 1; else m_st = 3;
        3: m_imr = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(bit a, string tag);
    logic [7:0] e, d;
    e = exp_read(a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
    if (!a && m_poll) m_poll = 0;
    chk(tag, int'(d), int'(e));
  endtask

  task automatic raise(int l);
    @(negedge clk);
    irq_req[l] = 1'b1;
    repeat (3) @(negedge clk);
    irq_req[l] = 1'b0;
    repeat (3) @(negedge clk);
    if (m_st == 3 && !m_imr[l]) m_irr[l] = 1'b1;
  endtask

  task automatic ack();
    int p;
    p = top_of(m_irr & ~m_imr, m_lp);
    @(negedge clk);
    int_ready = 1'b1;
    @(posedge clk);
    #1 int_ready = 1'b0;
    m_irr[p] = 1'b0; m_isr[p] = 1'b1;
  endtask

  // R14: acknowledge and command write in one cycle
  task automatic ack_with_write(logic [7:0] d);
    int p;
    p = top_of(m_irr & ~m_imr, m_lp);
    @(negedge clk);
    int_ready = 1'b1; reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk);
    #1 int_ready = 1'b0; reg_wr = 1'b0;
    model_write(1'b0, d);
    m_irr[p] = 1'b0; m_isr[p] = 1'b1;
  endtask

  task automatic chk_out(string tag);
    bit ev;
    int p;
    ev = exp_valid();
    p = top_of(m_irr & ~m_imr, m_lp);
    chk({tag, " valid"}, int'(int_valid), int'(ev));
    if (ev && int_valid) chk({tag, " vector"}, int'(int_vector), int'({m_base, 3'(p)}));
    chk({tag, " err"}, int'(cmd_err), int'(m_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R13 reset state
    chk_out("R13");
    rd_chk(1'b1, "R13 mask");
    rd_chk(1'b0, "R13 pending");

    // R3 cascade rejected
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h40);
    chk_out("R3");
    wr(1'b1, 8'h55);
    rd_chk(1'b1, "R3 unconfigured ignores mask");
    do_reset();

    // R4 unsupported mode word, then a good one; R5 mask
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h02);
    chk_out("R4");
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h55);
    rd_chk(1'b1, "R5 mask readback");
    do_reset();

    // R6 requests before setup dropped
    raise(3);
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h48);
    rd_chk(1'b0, "R6 pre-setup dropped");
    chk_out("R2");
    wr(1'b1, 8'h04);
    raise(2);
    rd_chk(1'b0, "R6 masked dropped");

    // R7 priority and blocking
    raise(5);
    raise(1);
    chk_out("R7 winner");
    ack();
    chk_out("R7 blocked by service");
    // R11 poll
    wr(1'b0, 8'h0C);
    rd_chk(1'b0, "R11 poll");
    rd_chk(1'b0, "R11 poll disarmed");
    // R8 non-specific end
    wr(1'b0, 8'h20);
    chk_out("R8 plain");
    ack();
    // R9 specific rotate
    wr(1'b0, 8'hE5);
    raise(4);
    raise(7);
    chk_out("R9 rotate");
    wr(1'b0, 8'hC3);
    chk_out("R9 set low");
    wr(1'b0, 8'h40);
    chk_out("R9 nop");
    // R8 rotate
    ack();
    chk_out("R8 blocked");
    wr(1'b0, 8'hA0);
    chk_out("R8 rotate");
    // R14 acknowledge with specific end of the same level
    ack_with_write(8'h67);
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, "R14 isr after combined cycle");
    chk_out("R14");
    // R10 pending select
    wr(1'b0, 8'h0A);
    rd_chk(1'b0, "R10 pending select");
    // R12 unsupported commands
    wr(1'b0, 8'h80);
    chk_out("R12 auto code");
    wr(1'b0, 8'h68);
    chk_out("R12 special mask");
    rd_chk(1'b0, "R12 registers kept");
    do_reset();

    // random phase
    void'($urandom(32'd715));
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h90);
    wr(1'b1, 8'h01);
    for (int it = 0; it < 500; it++) begin
      int op, n;
      op = int'($urandom % 9);
      n  = int'($urandom % 8);
      case (op)
        0, 1: begin raise(n); chk_out("R6 random raise"); end
        2: if (exp_valid()) begin ack(); chk_out("R7 random ack"); end
        3: begin
          case ($urandom % 6)
            0: wr(1'b0, 8'h20);
            1: wr(1'b0, 8'hA0);
            2: wr(1'b0, 8'h60 | 8'(n));
            3: wr(1'b0, 8'hE0 | 8'(n));
            4: wr(1'b0, 8'hC0 | 8'(n));
            default: wr(1'b0, 8'h40);
          endcase
          chk_out("R9 random command");
        end
        4: begin wr(1'b1, 8'($urandom & $urandom & $urandom)); chk_out("R5 random mask"); end
        5: begin wr(1'b0, 8'h0A); rd_chk(1'b0, "R10 random pending"); end
        6: begin wr(1'b0, 8'h0B); rd_chk(1'b0, "R10 random isr"); end
        7: begin wr(1'b0, 8'h0C); rd_chk(1'b0, "R11 random poll"); end
        default: if (exp_valid()) begin
          ack_with_write(8'h20);
          wr(1'b0, 8'h0B);
          rd_chk(1'b0, "R14 random combined");
        end
      endcase
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule